// File: doc/BRIEF.md
# Preset-Control Arithmetic Logic Unit

This block is a combinational datapath unit that combines two operand words into one result word and reports two status flags. It has no opcode. Six independent control inputs pick the function. Four of them condition the operands before the core. Each operand can first be cleared and then bit-inverted. One bit picks what the core does: a wrapping binary sum or a bitwise AND. The last bit can invert the core result on its way to the output. Through these pre- and post-conditioning steps, a single adder and a single AND array also give subtraction, negation, increment, decrement, OR and the constants, with no dedicated hardware for any of them.

The result is valid within the same cycle as the inputs, because there is no clock and no storage. A surrounding processor drives the six control bits straight from a field of an instruction word. It then uses the two flags for branch decisions. The word width is a parameter and defaults to 16 bits. The adder can be built either as an explicit ripple chain or as an inferred sum.

Top module: `alu6_top`

## Requirements
- R1: The X operand is conditioned in a fixed order. If `clr_x` is 1 it becomes 0, and after that, if `inv_x` is 1, it becomes its bitwise complement. With `clr_x=1, inv_x=1` the conditioned X is all ones.
- R2: The Y operand is conditioned the same way by `clr_y`, then `inv_y`.
- R3: With `add_sel=1` the core value is the sum of the conditioned operands modulo 2^WIDTH. The carry out of the top bit is discarded.
- R4: With `add_sel=0` the core value is the bitwise AND of the conditioned operands.
- R5: With `inv_res=1` the output `result` is the bitwise complement of the core value; otherwise it is the core value.
- R6: `res_zero` is 1 exactly when `result` is all zeros. It is computed from the output after inversion.
- R7: `res_neg` is 1 exactly when the top bit of `result` (bit 15 by default) is 1. It is computed from the output after inversion.
- R8: Write the control vector as {clr_x, inv_x, clr_y, inv_y, add_sel, inv_res}. Then these encodings give these functions: 000010 X+Y, 000000 X&Y, 000111 Y-X, 010011 X-Y, 010101 X|Y, 001101 ~X, 110001 ~Y, 101010 0, 111111 1, 111010 -1, 001100 X, 110000 Y, 011111 X+1, 001110 X-1.
- R9: The outputs follow a change of any input without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand |
| clr_x | input | 1 | Force X to zero |
| inv_x | input | 1 | Complement X, applied after clearing |
| clr_y | input | 1 | Force Y to zero |
| inv_y | input | 1 | Complement Y, applied after clearing |
| add_sel | input | 1 | 1 selects the sum, 0 selects AND |
| inv_res | input | 1 | Complement the core value |
| result | output | WIDTH | Final result word |
| res_zero | output | 1 | Result is zero |
| res_neg | output | 1 | Result top bit is set |

## Verification
The assertions assume that every operand and control input is at a known 0 or 1 level. They check nothing while any input carries X or Z. They also assume that the outputs have settled from the current inputs by the time they are evaluated. The bench meets both assumptions. It drives every input to a defined value from the first cycle, holds each combination for a full clock period, and samples half a period later. The sweep crosses all 64 control combinations with a set of operand pairs: all-zeros, all-ones, sign-boundary words, carry-rippling pairs and generated patterns.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
   localparam int CTRL_W = 6;

   typedef struct packed {
      logic clr_x;
      logic inv_x;
      logic clr_y;
      logic inv_y;
      logic add_sel;
      logic inv_res;
   } alu6_ctrl_t;
endpackage

// File: rtl/alu6_opnd_cond.sv
module alu6_opnd_cond #(
   parameter int W = 16
) (
   input  logic [W-1:0] raw,
   input  logic         clr,
   input  logic         inv,
   output logic [W-1:0] cond
);
   logic [W-1:0] cleared;

   always_comb begin
      cleared = clr ? '0 : raw;
      cond    = inv ? ~cleared : cleared;
   end
endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
   parameter int W          = 16,
   parameter bit ADD_RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         add_sel,
   output logic [W-1:0] core
);
   logic [W-1:0] sum;
   logic [W-1:0] conj;

   assign conj = a & b;

   if (ADD_RIPPLE) begin : g_ripple
      logic [W-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i] = a[i] ^ b[i] ^ cy[i];
         if (i < W - 1) begin : g_cy
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
      end
   end else begin : g_infer
      assign sum = a + b;
   end

   assign core = add_sel ? sum : conj;
endmodule

// File: rtl/alu6_flags.sv
module alu6_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] r,
   output logic         zero,
   output logic         neg
);
   assign zero = ~|r;
   assign neg  = r[W-1];
endmodule

// File: rtl/alu6_top.sv
module alu6_top #(
   parameter int WIDTH      = 16,
   parameter bit ADD_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_x,
   input  logic [WIDTH-1:0] opnd_y,
   input  logic             clr_x,
   input  logic             inv_x,
   input  logic             clr_y,
   input  logic             inv_y,
   input  logic             add_sel,
   input  logic             inv_res,
   output logic [WIDTH-1:0] result,
   output logic             res_zero,
   output logic             res_neg
);
   import alu6_pkg::*;

   localparam int N_OPND = 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu6_top: WIDTH must be at least 2");
   end

   alu6_ctrl_t       ctl;
   logic [WIDTH-1:0] raw_op  [N_OPND];
   logic [WIDTH-1:0] cond_op [N_OPND];
   logic             clr_op  [N_OPND];
   logic             inv_op  [N_OPND];
   logic [WIDTH-1:0] px;
   logic [WIDTH-1:0] py;
   logic [WIDTH-1:0] core_res;

   assign ctl = '{clr_x: clr_x, inv_x: inv_x, clr_y: clr_y, inv_y: inv_y,
                  add_sel: add_sel, inv_res: inv_res};

   assign raw_op[0] = opnd_x;
   assign raw_op[1] = opnd_y;
   assign clr_op[0] = ctl.clr_x;
   assign clr_op[1] = ctl.clr_y;
   assign inv_op[0] = ctl.inv_x;
   assign inv_op[1] = ctl.inv_y;

   for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
      alu6_opnd_cond #(.W(WIDTH)) cond_i (
         .raw  (raw_op[k]),
         .clr  (clr_op[k]),
         .inv  (inv_op[k]),
         .cond (cond_op[k])
      );
   end

   assign px = cond_op[0];
   assign py = cond_op[1];

   alu6_core #(.W(WIDTH), .ADD_RIPPLE(ADD_RIPPLE)) core_i (
      .a       (px),
      .b       (py),
      .add_sel (ctl.add_sel),
      .core    (core_res)
   );

   assign result = ctl.inv_res ? ~core_res : core_res;

   alu6_flags #(.W(WIDTH)) flags_i (
      .r    (result),
      .zero (res_zero),
      .neg  (res_neg)
   );
endmodule

// File: rtl/alu6_chk.sv
module alu6_chk #(
   parameter int W = 16
) (
   input logic [W-1:0] opnd_x,
   input logic [W-1:0] opnd_y,
   input logic         clr_x,
   input logic         inv_x,
   input logic         clr_y,
   input logic         inv_y,
   input logic         add_sel,
   input logic         inv_res,
   input logic [W-1:0] px,
   input logic [W-1:0] py,
   input logic [W-1:0] core_res,
   input logic [W-1:0] result,
   input logic         res_zero,
   input logic         res_neg
);
   logic known;
   assign known = !$isunknown({opnd_x, opnd_y, clr_x, inv_x, clr_y, inv_y, add_sel, inv_res});

   always_comb begin
      if (known) begin
         // R1
         x_cond_chk: assert (px == (inv_x ? ~(clr_x ? '0 : opnd_x) : (clr_x ? '0 : opnd_x)))
            else $error("x conditioning wrong");
         // R2
         y_cond_chk: assert (py == (inv_y ? ~(clr_y ? '0 : opnd_y) : (clr_y ? '0 : opnd_y)))
            else $error("y conditioning wrong");
         // R3
         sum_chk: assert (!add_sel || core_res == W'(px + py))
            else $error("sum wrong");
         // R4
         and_chk: assert (add_sel || core_res == (px & py))
            else $error("and wrong");
         // R5
         post_inv_chk: assert (result == (inv_res ? ~core_res : core_res))
            else $error("post inversion wrong");
         // R6
         res_zero_chk: assert (res_zero == (result == '0))
            else $error("zero flag wrong");
         // R7
         res_neg_chk: assert (res_neg == result[W-1])
            else $error("negative flag wrong");
      end
   end
endmodule

bind alu6_top alu6_chk #(.W(WIDTH)) chk_i (
   .opnd_x   (opnd_x),
   .opnd_y   (opnd_y),
   .clr_x    (clr_x),
   .inv_x    (inv_x),
   .clr_y    (clr_y),
   .inv_y    (inv_y),
   .add_sel  (add_sel),
   .inv_res  (inv_res),
   .px       (px),
   .py       (py),
   .core_res (core_res),
   .result   (result),
   .res_zero (res_zero),
   .res_neg  (res_neg)
);

// File: tb/alu6_top_tb_top.sv
module alu6_top_tb_top;
   localparam int W    = 16;
   localparam int MASK = 65535;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] opnd_x = '0, opnd_y = '0;
   logic clr_x = 0, inv_x = 0, clr_y = 0, inv_y = 0, add_sel = 0, inv_res = 0;
   logic [W-1:0] result;
   logic res_zero, res_neg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   alu6_top #(.WIDTH(W)) dut_i (
      .opnd_x(opnd_x), .opnd_y(opnd_y),
      .clr_x(clr_x), .inv_x(inv_x), .clr_y(clr_y), .inv_y(inv_y),
      .add_sel(add_sel), .inv_res(inv_res),
      .result(result), .res_zero(res_zero), .res_neg(res_neg)
   );

   // control vector {clr_x, inv_x, clr_y, inv_y, add_sel, inv_res}
   task automatic apply(input logic [5:0] c, input int x, input int y);
      {clr_x, inv_x, clr_y, inv_y, add_sel, inv_res} = c;
      opnd_x = W'(x);
      opnd_y = W'(y);
   endtask

   function automatic int ref_alu(input logic [5:0] c, input int x, input int y);
      int a, b, r;
      a = c[5] ? 0 : x;
      if (c[4]) a = MASK - a;
      b = c[3] ? 0 : y;
      if (c[2]) b = MASK - b;
      r = c[1] ? (a + b) % 65536 : (a & b);
      if (c[0]) r = MASK - r;
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic [5:0] c, input int x, input int y);
      @(posedge clk); #1;
      apply(c, x, y);
      @(negedge clk);
   endtask

   int xs[20];
   int ys[20];

   initial begin
      int seed;
      int r;
      xs[0] = 0;      ys[0] = 0;
      xs[1] = MASK;   ys[1] = MASK;
      xs[2] = 32767;  ys[2] = 1;
      xs[3] = 32768;  ys[3] = 32768;
      xs[4] = 1;      ys[4] = MASK;
      xs[5] = 21845;  ys[5] = 43690;
      xs[6] = 17;     ys[6] = 3;
      xs[7] = 3;      ys[7] = 17;
      seed = 12345;
      for (int i = 8; i < 20; i++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         xs[i] = (seed >> 8) & MASK;
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         ys[i] = (seed >> 8) & MASK;
      end

      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state: all inputs zero, AND of zeros
      @(negedge clk);
      check("R4 reset result", int'(result), 0);
      check("R6 reset zero flag", int'(res_zero), 1);

      // full sweep of all 64 control combinations
      for (int c = 0; c < 64; c++) begin
         for (int p = 0; p < 20; p++) begin
            step(6'(c), xs[p], ys[p]);
            r = ref_alu(6'(c), xs[p], ys[p]);
            if (c[0])      check("R5 result", int'(result), r);
            else if (c[1]) check("R3 result", int'(result), r);
            else           check("R4 result", int'(result), r);
            check("R6 zero flag", int'(res_zero), (r == 0) ? 1 : 0);
            check("R7 neg flag", int'(res_neg), (r >> 15) & 1);
         end
      end

      // R1: pass conditioned X through adder with Y forced to zero
      for (int m = 0; m < 4; m++) begin
         step({m[1], m[0], 4'b1010}, 16'h1234, 16'h5555);
         check("R1 x cond", int'(result),
               m[1] ? (m[0] ? MASK : 0) : (m[0] ? MASK - 16'h1234 : 16'h1234));
      end
      // R2: pass conditioned Y with X forced to zero
      for (int m = 0; m < 4; m++) begin
         step({2'b10, m[1], m[0], 2'b10}, 16'h5555, 16'h00F0);
         check("R2 y cond", int'(result),
               m[1] ? (m[0] ? MASK : 0) : (m[0] ? MASK - 16'h00F0 : 16'h00F0));
      end

      // R3 carry discard
      step(6'b000010, MASK, 1);
      check("R3 wrap", int'(result), 0);
      check("R6 wrap zero", int'(res_zero), 1);

      // R8 named encodings, expected from the function meaning
      for (int p = 0; p < 20; p++) begin
         int x, y;
         x = xs[p]; y = ys[p];
         step(6'b000010, x, y); check("R8 x+y", int'(result), (x + y) % 65536);
         step(6'b000000, x, y); check("R8 x&y", int'(result), x & y);
         step(6'b000111, x, y); check("R8 y-x", int'(result), (y - x + 65536) % 65536);
         step(6'b010011, x, y); check("R8 x-y", int'(result), (x - y + 65536) % 65536);
         step(6'b010101, x, y); check("R8 x|y", int'(result), x | y);
         step(6'b001101, x, y); check("R8 ~x", int'(result), MASK ^ x);
         step(6'b110001, x, y); check("R8 ~y", int'(result), MASK ^ y);
         step(6'b101010, x, y); check("R8 zero", int'(result), 0);
         step(6'b111111, x, y); check("R8 one", int'(result), 1);
         step(6'b111010, x, y); check("R8 minus one", int'(result), MASK);
         step(6'b001100, x, y); check("R8 x", int'(result), x);
         step(6'b110000, x, y); check("R8 y", int'(result), y);
         step(6'b011111, x, y); check("R8 x+1", int'(result), (x + 1) % 65536);
         step(6'b001110, x, y); check("R8 x-1", int'(result), (x + 65535) % 65536);
      end

      // R9: outputs change between clock edges with no edge in between
      @(posedge clk); #1;
      apply(6'b000010, 100, 23);
      #1;
      check("R9 comb update", int'(result), 123);
      apply(6'b000010, 100, 24);
      #1;
      check("R9 comb update 2", int'(result), 124);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule